// File: doc/BRIEF.md
# Maskable Level Interrupt Controller

This block gathers thirty-two level-sensitive interrupt lines into a single request for a processor. Each line passes through a two-stage synchronizer. A 32-bit mask then gates it, where a 1 in the mask blocks the line. Software reaches the block over a small synchronous register bus. It can read the synchronized raw levels, the mask, and the pending set, which is the raw levels with the masked lines removed.

The mask never needs a read-modify-write. Two write-only strobe words change it: one sets the mask bits written as 1, the other clears them, and all other bits keep their value. Sources are levels, so there is no acknowledge. A pending line stays pending until its source drops or software masks it.

As a convenience, the block also reports on registered outputs the index of the highest-numbered pending line and a flag that says whether any line is pending. A handler can service that line first.

Top module: `lic_ctrl`

## Requirements
- R1: After reset the mask is all ones. `irq_o`, `top_vld_o`, `top_idx_o` and `bus_rdata_o` are zero.
- R2: A write to word offset 0x08 sets every mask bit whose data bit is 1 and leaves every other mask bit unchanged. The new mask is in effect from the next clock edge.
- R3: A write to word offset 0x0C clears every mask bit whose data bit is 1 and leaves every other mask bit unchanged.
- R4: A read of word offset 0x10 returns the synchronized source levels AND NOT the mask. Bit n belongs to source n.
- R5: A read of word offset 0x00 returns the synchronized source levels whatever the mask holds.
- R6: `irq_o` is high exactly when some line is pending. A source rising at the input shows on `irq_o` at the third rising clock edge. A mask change shows at the edge after the write.
- R7: When any line is pending, `top_vld_o` is 1 and `top_idx_o` gives the highest-numbered pending line as an unsigned 5-bit index. With nothing pending, `top_vld_o` is 0.
- R8: A pending line stays pending, and `irq_o` stays high, for as long as its source is high and unmasked. Reading any register does not clear it. It drops three edges after the source falls.
- R9: A read of word offset 0x08 or 0x0C returns zero. Writes to offsets 0x00, 0x04 and 0x10, and to any unmapped offset, leave the mask unchanged. Unmapped offsets read as zero.
- R10: A read returns its data on `bus_rdata_o` after the clock edge that samples `bus_rd_i`. The value holds until the next read.
- R11: A read of word offset 0x04 returns the current mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| src_i | input | 32 | Level-sensitive interrupt sources, asynchronous |
| bus_addr_i | input | 5 | Byte address; bits 1:0 ignored |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |
| top_idx_o | output | 5 | Highest-numbered pending line |
| top_vld_o | output | 1 | Some line is pending |

## Verification
The assertions assume that the bus never raises a read and a write in the same cycle. They also assume that each write strobe lasts one cycle, so every write is one mask update. The bench's bus tasks drive exactly one strobe for one cycle. They apply new source levels at falling edges and hold them for at least three cycles, so each level crosses the synchronizer before it is checked. The pick and request assertions relate each registered output to the pending set of the cycle before. This holds only because the sources change no more than once per cycle.

// File: rtl/lic_pkg.sv
`timescale 1ns/1ps
package lic_pkg;
  localparam int LIC_LINES = 32;
  localparam int LIC_W_RAW  = 0;
  localparam int LIC_W_MASK = 1;
  localparam int LIC_W_SET  = 2;
  localparam int LIC_W_CLR  = 3;
  localparam int LIC_W_PEND = 4;
endpackage

// File: rtl/lic_sync.sv
`timescale 1ns/1ps
module lic_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else if (s == 0) stg[s] <= d_i;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/lic_mask_reg.sv
`timescale 1ns/1ps
module lic_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb_i,
  input  logic         clr_stb_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] mask_o
);
  // set wins nowhere: strobes are mutually exclusive by address decode
  function automatic logic [W-1:0] mask_next(input logic [W-1:0] cur,
                                             input logic [W-1:0] bits,
                                             input logic set_s,
                                             input logic clr_s);
    logic [W-1:0] r;
    r = cur;
    if (set_s) r = r | bits;
    if (clr_s) r = r & ~bits;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_o <= '1;
    else        mask_o <= mask_next(mask_o, bits_i, set_stb_i, clr_stb_i);
  end
endmodule

// File: rtl/lic_pick.sv
`timescale 1ns/1ps
module lic_pick #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // ascending scan; the last set bit seen is the highest one
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/lic_ctrl.sv
`timescale 1ns/1ps
module lic_ctrl #(
  parameter int NSRC   = lic_pkg::LIC_LINES,
  parameter int ADDR_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          src_i,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic                     bus_wr_i,
  input  logic [NSRC-1:0]          bus_wdata_i,
  input  logic                     bus_rd_i,
  output logic [NSRC-1:0]          bus_rdata_o,
  output logic                     irq_o,
  output logic [$clog2(NSRC)-1:0]  top_idx_o,
  output logic                     top_vld_o
);
  import lic_pkg::*;

  localparam int IDX_W = $clog2(NSRC);
  localparam int WSEL_W = ADDR_W - 2;

  logic [WSEL_W-1:0] word_sel;
  logic              set_hit, clr_hit;
  logic [NSRC-1:0]   src_sync, mask_q, pend;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_any;

  function automatic logic [NSRC-1:0] read_mux(input logic [WSEL_W-1:0] w,
                                               input logic [NSRC-1:0] raw,
                                               input logic [NSRC-1:0] msk,
                                               input logic [NSRC-1:0] pnd);
    case (int'(w))
      LIC_W_RAW:  return raw;
      LIC_W_MASK: return msk;
      LIC_W_PEND: return pnd;
      default:    return '0;
    endcase
  endfunction

  assign word_sel = bus_addr_i[ADDR_W-1:2];
  assign set_hit  = bus_wr_i && (word_sel == WSEL_W'(LIC_W_SET));
  assign clr_hit  = bus_wr_i && (word_sel == WSEL_W'(LIC_W_CLR));

  lic_sync #(.W(NSRC), .STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(src_sync)
  );

  lic_mask_reg #(.W(NSRC)) mask_i (
    .clk(clk), .rst_n(rst_n), .set_stb_i(set_hit), .clr_stb_i(clr_hit),
    .bits_i(bus_wdata_i), .mask_o(mask_q)
  );

  assign pend = src_sync & ~mask_q;

  lic_pick #(.W(NSRC), .IW(IDX_W)) pick_i (
    .vec_i(pend), .idx_o(pick_idx), .any_o(pick_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o       <= 1'b0;
      top_vld_o   <= 1'b0;
      top_idx_o   <= '0;
      bus_rdata_o <= '0;
    end else begin
      irq_o     <= pick_any;
      top_vld_o <= pick_any;
      top_idx_o <= pick_idx;
      if (bus_rd_i) bus_rdata_o <= read_mux(word_sel, src_sync, mask_q, pend);
    end
  end
endmodule

// File: rtl/lic_ctrl_chk.sv
`timescale 1ns/1ps
module lic_ctrl_chk #(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [ADDR_W-1:0]       bus_addr_i,
  input logic                    bus_wr_i,
  input logic [NSRC-1:0]         bus_wdata_i,
  input logic [NSRC-1:0]         mask_q,
  input logic [NSRC-1:0]         pend,
  input logic                    irq_o,
  input logic [$clog2(NSRC)-1:0] top_idx_o,
  input logic                    top_vld_o
);
  logic wr_set, wr_clr;
  assign wr_set = bus_wr_i && (int'(bus_addr_i[ADDR_W-1:2]) == 2);
  assign wr_clr = bus_wr_i && (int'(bus_addr_i[ADDR_W-1:2]) == 3);

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((mask_q & $past(bus_wdata_i)) == $past(bus_wdata_i)) &&
               ((mask_q & ~$past(bus_wdata_i)) == ($past(mask_q) & ~$past(bus_wdata_i))));

  assert_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((mask_q & $past(bus_wdata_i)) == '0) &&
               ((mask_q & ~$past(bus_wdata_i)) == ($past(mask_q) & ~$past(bus_wdata_i))));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(mask_q));

  assert_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & mask_q) == '0);

  assert_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == ($past(pend) != '0)) && (irq_o == top_vld_o));

  assert_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    top_vld_o |-> (($past(pend) >> top_idx_o) == NSRC'(1)));
endmodule

bind lic_ctrl lic_ctrl_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
  .bus_wdata_i(bus_wdata_i), .mask_q(mask_q), .pend(pend), .irq_o(irq_o),
  .top_idx_o(top_idx_o), .top_vld_o(top_vld_o)
);

// File: tb/lic_ctrl_tb_top.sv
`timescale 1ns/1ps
module lic_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [4:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, vld;
  logic [4:0]  idx;

  int n_run = 0, n_fail = 0;
  logic [31:0] m_mask;
  logic [31:0] m_src;

  always #5 clk = ~clk;

  lic_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rd_i(rd), .bus_rdata_o(rdata), .irq_o(irq),
    .top_idx_o(idx), .top_vld_o(vld)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int hi_bit(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) return i;
    return 0;
  endfunction

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    if (a == 5'h08) m_mask = m_mask | d;
    if (a == 5'h0C) m_mask = m_mask & ~d;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic put_src(input logic [31:0] v);
    @(negedge clk); src = v; m_src = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_outputs(input string req);
    logic [31:0] p;
    p = m_src & ~m_mask;
    chk(req, {31'b0, irq}, {31'b0, p != 0});
    chk(req, {31'b0, vld}, {31'b0, p != 0});
    if (p != 0) chk(req, {27'b0, idx}, hi_bit(p));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 vld", {31'b0, vld}, 0);
    chk("R1 idx", {27'b0, idx}, 0);
    chk("R1 rdata", rdata, 0);
    bus_read(5'h04, d); chk("R1 mask", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_set_clear;
    logic [31:0] d;
    bus_write(5'h0C, 32'h0000_00F0);
    bus_read(5'h04, d); chk("R3 clear", d, 32'hFFFF_FF0F);
    bus_write(5'h08, 32'h0000_0030);
    bus_read(5'h04, d); chk("R2 set", d, 32'hFFFF_FF3F);
    bus_write(5'h0C, 32'h0);
    bus_read(5'h04, d); chk("R11 mask readback", d, m_mask);
    bus_write(5'h0C, 32'hFFFF_FFFF);
    bus_read(5'h04, d); chk("R3 clear all", d, 32'h0);
    bus_write(5'h08, 32'h8000_0000);
    bus_read(5'h04, d); chk("R2 set top", d, 32'h8000_0000);
  endtask

  task automatic t_status;
    logic [31:0] d;
    put_src(32'hA5A5_8001);
    bus_read(5'h00, d); chk("R5 raw", d, 32'hA5A5_8001);
    bus_read(5'h10, d); chk("R4 pending", d, 32'hA5A5_8001 & ~m_mask);
    check_outputs("R7 masked top");
    chk("R7 idx masked top", {27'b0, idx}, 29);
  endtask

  task automatic t_latency;
    put_src(32'h0);
    bus_write(5'h0C, 32'hFFFF_FFFF);
    @(negedge clk); src = 32'h0000_0400; m_src = src;
    @(negedge clk); chk("R6 edge1", {31'b0, irq}, 0);
    @(negedge clk); chk("R6 edge2", {31'b0, irq}, 0);
    @(negedge clk); chk("R6 edge3", {31'b0, irq}, 1);
    chk("R7 idx10", {27'b0, idx}, 10);
    // masking through set strobe takes effect one edge later
    @(negedge clk); addr = 5'h08; wdata = 32'h0000_0400; wr = 1'b1;
    @(negedge clk); wr = 1'b0; m_mask = m_mask | 32'h400;
    chk("R6 mask lag", {31'b0, irq}, 1);
    @(negedge clk); chk("R6 masked", {31'b0, irq}, 0);
    bus_write(5'h0C, 32'h0000_0400);
    @(negedge clk); chk("R6 unmasked", {31'b0, irq}, 1);
  endtask

  task automatic t_priority;
    put_src(32'h0000_0001); check_outputs("R7 bit0");
    chk("R7 idx0", {31'b0, vld}, 1);
    put_src(32'h8000_0000); check_outputs("R7 bit31");
    put_src(32'h0001_0100); check_outputs("R7 bit16");
    put_src(32'h7FFF_FFFF); check_outputs("R7 bit30");
    put_src(32'h0);         check_outputs("R7 none");
  endtask

  task automatic t_level;
    logic [31:0] d;
    put_src(32'h0002_0000);
    bus_read(5'h10, d); chk("R8 pend1", d, 32'h0002_0000);
    bus_read(5'h10, d); chk("R8 pend2", d, 32'h0002_0000);
    repeat (5) @(negedge clk);
    chk("R8 irq held", {31'b0, irq}, 1);
    @(negedge clk); src = 32'h0; m_src = 0;
    @(negedge clk); @(negedge clk);
    chk("R8 not yet", {31'b0, irq}, 1);
    @(negedge clk); chk("R8 dropped", {31'b0, irq}, 0);
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    bus_write(5'h08, 32'h0F0F_0000);
    bus_write(5'h00, 32'hFFFF_FFFF);
    bus_write(5'h04, 32'hFFFF_FFFF);
    bus_write(5'h10, 32'h0000_FFFF);
    bus_write(5'h14, 32'h1234_5678);
    bus_write(5'h1C, 32'hFFFF_FFFF);
    bus_read(5'h04, d); chk("R9 mask unchanged", d, m_mask);
    bus_read(5'h08, d); chk("R9 set reads 0", d, 0);
    bus_read(5'h0C, d); chk("R9 clr reads 0", d, 0);
    bus_read(5'h18, d); chk("R9 unmapped reads 0", d, 0);
  endtask

  task automatic t_read_hold;
    logic [31:0] d;
    put_src(32'h0000_00C3);
    bus_read(5'h00, d); chk("R10 read", d, 32'h0000_00C3);
    put_src(32'h0000_0011);
    chk("R10 hold", rdata, 32'h0000_00C3);
    bus_read(5'h00, d); chk("R10 new read", d, 32'h0000_0011);
  endtask

  initial begin
    m_mask = 32'hFFFF_FFFF; m_src = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set_clear();
    t_status();
    t_latency();
    t_priority();
    t_level();
    t_ignored();
    t_read_hold();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule